// File: doc/BRIEF.md
# Hall Sensor Interval Capture Bank

This block measures the time a brushless motor spends in each Hall sensor state. Each of the three sensor phases has its own counter. The counter counts clock cycles since that phase last changed level. It restarts at zero on every change and stops at its maximum instead of wrapping. A separate timer runs freely beside the three counters.

The three phase counts, the timer and a packed status word are copied as one coherent group into storage sets. There are four sets: the live set, a read set, and two snapshot sets that form a short stack. Software loads the read set with a command, and any enabled event from the neighbouring phase-event logic also loads it. A rising edge on an external snapshot pin pushes the live set onto the snapshot stack. For every phase, the block also keeps the count reached just before the last rising edge and just before the last falling edge.

Software selects one set and one phase's edge history through a read port. The selected values appear one cycle later on registered outputs.

Top module: `hall_capture_bank`

## Requirements
- R1: Each phase counter (CNT_W bits) becomes 0 on the clock edge that sees its level differ from the previously sampled level. On every other edge it increments by 1, and it holds at 2^CNT_W-1 once it reaches that value.
- R2: The timer (TMR_W bits) increments by 1 on every clock edge and wraps from all ones to zero.
- R3: When `read_cmd_i` is high at an edge, the read set takes all four live values on that edge. Set numbers on `grp_sel_i`: 0 live, 1 read, 2 snapshot 0, 3 snapshot 1.
- R4: When any bit of `evt_i` is high together with the same bit of `evt_rd_en_i`, the read set loads as in R3. An event whose enable bit is low leaves the read set unchanged.
- R5: A 0-to-1 change of `snap_i` while `snap_en_i` is high loads the live values into snapshot 0 and moves the old snapshot 0 into snapshot 1, both on the same edge. With `snap_en_i` low, both snapshot sets are left unchanged.
- R6: When a phase rises, its rising-edge history takes the count that phase held just before the edge. When a phase falls, its falling-edge history does the same.
- R7: The U word packs the registered direction in bit CNT_W+3, the U, V and W levels in bits CNT_W+2, CNT_W+1 and CNT_W, and the U count in the low CNT_W bits. The V and W words carry only their counts, with the top four bits set to zero.
- R8: `clr_cmd_i` clears the counters, the timer, all three stored sets and all history on a single edge. The clear takes priority over any load requested on that same edge.
- R9: After a synchronous reset, every output and all internal state read as zero.
- R10: Outputs are registered and show the selection made one cycle earlier. `hist_sel_i` picks the phase: 0 selects U, 1 selects V, 2 selects W, and 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_lvl_i | input | 3 | Synchronized levels, bit 2 U, bit 1 V, bit 0 W |
| dir_i | input | 1 | Rotation direction from the neighbouring logic, 1 = reverse |
| evt_i | input | NEV | Single-cycle event strobes |
| evt_rd_en_i | input | NEV | Per-event enables for loading the read set |
| read_cmd_i | input | 1 | Software load of the read set |
| clr_cmd_i | input | 1 | Clear counters, timer, sets and history |
| snap_en_i | input | 1 | Enables the snapshot pin |
| snap_i | input | 1 | External snapshot pin, acts on its rising edge |
| grp_sel_i | input | 2 | Set select for the read port |
| hist_sel_i | input | 2 | Phase select for the history outputs |
| u_word_o | output | CNT_W+4 | U word of the selected set |
| v_word_o | output | CNT_W+4 | V word of the selected set |
| w_word_o | output | CNT_W+4 | W word of the selected set |
| tmr_o | output | TMR_W | Timer value of the selected set |
| hist_rise_o | output | CNT_W | Rising-edge history of the selected phase |
| hist_fall_o | output | CNT_W | Falling-edge history of the selected phase |

## Verification
A counter that fails to restart, or that wraps past its maximum, shows on the live U, V or W word one cycle after the edge where it goes wrong. A load missed or misrouted between sets shows up the next time that set is selected, and that set stays wrong until it is loaded again. The bench therefore steps the set and phase selectors through every value in rotation, a few cycles apart. A stack that shifts in the wrong order shows the newer values in snapshot 1. A clear that loses to a load shows non-zero data in the read set right after the clear.

// File: rtl/hall_cap_pkg.sv
package hall_cap_pkg;
  // read-port set numbers
  localparam logic [1:0] GRP_LIVE = 2'd0;
  localparam logic [1:0] GRP_READ = 2'd1;
  localparam logic [1:0] GRP_SNP0 = 2'd2;
  localparam logic [1:0] GRP_SNP1 = 2'd3;
  // level vector bit positions
  localparam int LVL_U = 2;
  localparam int LVL_V = 1;
  localparam int LVL_W = 0;
  localparam int NPH   = 3;
endpackage

// File: rtl/hall_phase_ctr.sv
module hall_phase_ctr #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             lvl_i,
  output logic             lvl_q_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hist_rise_o,
  output logic [CNT_W-1:0] hist_fall_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q_o     <= 1'b0;
      cnt_o       <= '0;
      hist_rise_o <= '0;
      hist_fall_o <= '0;
    end else begin
      lvl_q_o <= lvl_i;
      if (clr) begin
        cnt_o       <= '0;
        hist_rise_o <= '0;
        hist_fall_o <= '0;
      end else if (lvl_i != lvl_q_o) begin
        cnt_o <= '0;
        if (lvl_i) hist_rise_o <= cnt_o;
        else       hist_fall_o <= cnt_o;
      end else if (cnt_o != CNT_MAX) begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hall_group_bank.sv
module hall_group_bank #(
  parameter int GW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ld_read,
  input  logic          ld_snap,
  input  logic [GW-1:0] live_i,
  output logic [GW-1:0] rd_o,
  output logic [GW-1:0] s0_o,
  output logic [GW-1:0] s1_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_o <= '0;
      s0_o <= '0;
      s1_o <= '0;
    end else begin
      if (ld_read) rd_o <= live_i;
      if (ld_snap) begin
        s0_o <= live_i;
        s1_o <= s0_o;
      end
    end
  end
endmodule

// File: rtl/hall_capture_bank.sv
module hall_capture_bank
  import hall_cap_pkg::*;
#(
  parameter int CNT_W = 28,
  parameter int TMR_W = 32,
  parameter int NEV   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       hall_lvl_i,
  input  logic             dir_i,
  input  logic [NEV-1:0]   evt_i,
  input  logic [NEV-1:0]   evt_rd_en_i,
  input  logic             read_cmd_i,
  input  logic             clr_cmd_i,
  input  logic             snap_en_i,
  input  logic             snap_i,
  input  logic [1:0]       grp_sel_i,
  input  logic [1:0]       hist_sel_i,
  output logic [CNT_W+3:0] u_word_o,
  output logic [CNT_W+3:0] v_word_o,
  output logic [CNT_W+3:0] w_word_o,
  output logic [TMR_W-1:0] tmr_o,
  output logic [CNT_W-1:0] hist_rise_o,
  output logic [CNT_W-1:0] hist_fall_o
);
  localparam int WW = CNT_W + 4;
  localparam int GW = 3 * WW + TMR_W;

  logic [2:0]            lvl_q;
  logic [2:0][CNT_W-1:0] cnt_q;
  logic [2:0][CNT_W-1:0] hr_q;
  logic [2:0][CNT_W-1:0] hf_q;
  logic [TMR_W-1:0]      tmr_q;
  logic                  dir_q;
  logic                  snap_q;
  logic                  ld_read;
  logic                  ld_snap;
  logic [GW-1:0]         live_grp;
  logic [GW-1:0]         rd_grp;
  logic [GW-1:0]         s0_grp;
  logic [GW-1:0]         s1_grp;
  logic [GW-1:0]         sel_grp;

  for (genvar b = 0; b < NPH; b++) begin : g_ph
    hall_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .clr        (clr_cmd_i),
      .lvl_i      (hall_lvl_i[b]),
      .lvl_q_o    (lvl_q[b]),
      .cnt_o      (cnt_q[b]),
      .hist_rise_o(hr_q[b]),
      .hist_fall_o(hf_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q  <= '0;
      dir_q  <= 1'b0;
      snap_q <= 1'b0;
    end else begin
      tmr_q  <= clr_cmd_i ? '0 : tmr_q + 1'b1;
      dir_q  <= dir_i;
      snap_q <= snap_i;
    end
  end

  assign ld_read = read_cmd_i | (|(evt_i & evt_rd_en_i));
  assign ld_snap = snap_en_i & snap_i & ~snap_q;

  assign live_grp = {dir_q, lvl_q[LVL_U], lvl_q[LVL_V], lvl_q[LVL_W], cnt_q[LVL_U],
                     4'b0000, cnt_q[LVL_V],
                     4'b0000, cnt_q[LVL_W],
                     tmr_q};

  hall_group_bank #(.GW(GW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_cmd_i),
    .ld_read(ld_read),
    .ld_snap(ld_snap),
    .live_i (live_grp),
    .rd_o   (rd_grp),
    .s0_o   (s0_grp),
    .s1_o   (s1_grp)
  );

  always_comb begin
    case (grp_sel_i)
      GRP_LIVE: sel_grp = live_grp;
      GRP_READ: sel_grp = rd_grp;
      GRP_SNP0: sel_grp = s0_grp;
      default:  sel_grp = s1_grp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_word_o    <= '0;
      v_word_o    <= '0;
      w_word_o    <= '0;
      tmr_o       <= '0;
      hist_rise_o <= '0;
      hist_fall_o <= '0;
    end else begin
      u_word_o <= sel_grp[GW-1 -: WW];
      v_word_o <= sel_grp[GW-WW-1 -: WW];
      w_word_o <= sel_grp[GW-2*WW-1 -: WW];
      tmr_o    <= sel_grp[TMR_W-1:0];
      case (hist_sel_i)
        2'd0: begin hist_rise_o <= hr_q[LVL_U]; hist_fall_o <= hf_q[LVL_U]; end
        2'd1: begin hist_rise_o <= hr_q[LVL_V]; hist_fall_o <= hf_q[LVL_V]; end
        2'd2: begin hist_rise_o <= hr_q[LVL_W]; hist_fall_o <= hf_q[LVL_W]; end
        default: begin hist_rise_o <= '0; hist_fall_o <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/hall_capture_bank_chk.sv
module hall_capture_bank_chk #(
  parameter int CNT_W = 28,
  parameter int TMR_W = 32,
  parameter int GW    = 3 * (CNT_W + 4) + TMR_W
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             read_cmd,
  input logic             ld_snap,
  input logic             lvl_u_i,
  input logic             lvl_u_q,
  input logic [CNT_W-1:0] cnt_u,
  input logic [TMR_W-1:0] tmr,
  input logic [GW-1:0]    live,
  input logic [GW-1:0]    rd,
  input logic [GW-1:0]    s0,
  input logic [GW-1:0]    s1
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  a_r1_restart: assert property (@(posedge clk) disable iff (rst)
    (lvl_u_i != lvl_u_q && !clr) |=> (cnt_u == '0));

  a_r1_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_u == CMAX && lvl_u_i == lvl_u_q && !clr) |=> (cnt_u == CMAX));

  a_r2_tick: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (tmr == TMR_W'($past(tmr) + 1'b1)));

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (read_cmd && !clr) |=> (rd == $past(live)));

  a_r5_stack: assert property (@(posedge clk) disable iff (rst)
    (ld_snap && !clr) |=> (s0 == $past(live) && s1 == $past(s0)));

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tmr == '0 && cnt_u == '0 && rd == '0 && s0 == '0 && s1 == '0));
endmodule

bind hall_capture_bank hall_capture_bank_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clr     (clr_cmd_i),
  .read_cmd(read_cmd_i),
  .ld_snap (ld_snap),
  .lvl_u_i (hall_lvl_i[2]),
  .lvl_u_q (lvl_q[2]),
  .cnt_u   (cnt_q[2]),
  .tmr     (tmr_q),
  .live    (live_grp),
  .rd      (rd_grp),
  .s0      (s0_grp),
  .s1      (s1_grp)
);

// File: tb/hall_capture_bank_tb.sv
module hall_capture_bank_tb;
  localparam int CNT_W = 6;
  localparam int TMR_W = 8;
  localparam int NEV   = 7;
  localparam int WW    = CNT_W + 4;
  localparam int GW    = 3 * WW + TMR_W;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] hall_lvl_i = '0;
  logic dir_i = 1'b0;
  logic [NEV-1:0] evt_i = '0, evt_rd_en_i = '0;
  logic read_cmd_i = 1'b0, clr_cmd_i = 1'b0, snap_en_i = 1'b0, snap_i = 1'b0;
  logic [1:0] grp_sel_i = '0, hist_sel_i = '0;
  logic [WW-1:0] u_word_o, v_word_o, w_word_o;
  logic [TMR_W-1:0] tmr_o;
  logic [CNT_W-1:0] hist_rise_o, hist_fall_o;

  always #2 clk = ~clk;

  hall_capture_bank #(.CNT_W(CNT_W), .TMR_W(TMR_W), .NEV(NEV)) u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // arithmetic reference state
  logic [CNT_W-1:0] m_cnt [3];
  logic [CNT_W-1:0] m_hr [3];
  logic [CNT_W-1:0] m_hf [3];
  logic [2:0] m_lvl;
  logic m_dir, m_snq;
  logic [TMR_W-1:0] m_tmr;
  logic [GW-1:0] m_rd, m_s0, m_s1;
  logic [WW-1:0] e_u, e_v, e_w;
  logic [TMR_W-1:0] e_t;
  logic [CNT_W-1:0] e_hr, e_hf;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [GW-1:0] live_m();
    return {m_dir, m_lvl[2], m_lvl[1], m_lvl[0], m_cnt[2],
            4'b0000, m_cnt[1], 4'b0000, m_cnt[0], m_tmr};
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 3; b++) begin m_cnt[b] = '0; m_hr[b] = '0; m_hf[b] = '0; end
    m_lvl = '0; m_dir = 0; m_snq = 0; m_tmr = '0;
    m_rd = '0; m_s0 = '0; m_s1 = '0;
    e_u = '0; e_v = '0; e_w = '0; e_t = '0; e_hr = '0; e_hf = '0;
  endtask

  // one clock: predict, advance, compare at the falling edge
  task automatic step();
    logic [GW-1:0] lv, sg;
    int hb;
    if (rst) model_reset();
    else begin
      lv = live_m();
      case (grp_sel_i)
        2'd0: sg = lv;
        2'd1: sg = m_rd;
        2'd2: sg = m_s0;
        default: sg = m_s1;
      endcase
      e_u = sg[GW-1 -: WW]; e_v = sg[GW-WW-1 -: WW];
      e_w = sg[GW-2*WW-1 -: WW]; e_t = sg[TMR_W-1:0];
      hb = 2 - int'(hist_sel_i);
      if (hist_sel_i == 2'd3) begin e_hr = '0; e_hf = '0; end
      else begin e_hr = m_hr[hb]; e_hf = m_hf[hb]; end
      if (clr_cmd_i) begin
        m_rd = '0; m_s0 = '0; m_s1 = '0; m_tmr = '0;
        for (int b = 0; b < 3; b++) begin m_cnt[b] = '0; m_hr[b] = '0; m_hf[b] = '0; end
      end else begin
        if (read_cmd_i || (evt_i & evt_rd_en_i) != '0) m_rd = lv;
        if (snap_en_i && snap_i && !m_snq) begin m_s1 = m_s0; m_s0 = lv; end
        m_tmr = m_tmr + 1'b1;
        for (int b = 0; b < 3; b++) begin
          if (hall_lvl_i[b] != m_lvl[b]) begin
            if (hall_lvl_i[b]) m_hr[b] = m_cnt[b]; else m_hf[b] = m_cnt[b];
            m_cnt[b] = '0;
          end else if (m_cnt[b] != CMAX) m_cnt[b] = m_cnt[b] + 1'b1;
        end
      end
      m_lvl = hall_lvl_i; m_dir = dir_i; m_snq = snap_i;
    end
    @(posedge clk);
    @(negedge clk);
    case (grp_sel_i)
      2'd0: chk("R1 R7 live U word", 32'(u_word_o), 32'(e_u));
      2'd1: chk("R3 R4 read U word", 32'(u_word_o), 32'(e_u));
      default: chk("R5 snapshot U word", 32'(u_word_o), 32'(e_u));
    endcase
    chk("R1 V word", 32'(v_word_o), 32'(e_v));
    chk("R1 W word", 32'(w_word_o), 32'(e_w));
    chk("R2 timer", 32'(tmr_o), 32'(e_t));
    chk("R6 R10 rise history", 32'(hist_rise_o), 32'(e_hr));
    chk("R6 R10 fall history", 32'(hist_fall_o), 32'(e_hf));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] seq [6];
    int ph, dwell;
    seq[0] = 3'b100; seq[1] = 3'b110; seq[2] = 3'b010;
    seq[3] = 3'b011; seq[4] = 3'b001; seq[5] = 3'b101;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset values before the first active edge
    chk("R9 reset U", 32'(u_word_o), 0);
    chk("R9 reset timer", 32'(tmr_o), 0);
    chk("R9 reset history", 32'(hist_rise_o | hist_fall_o), 0);

    // R1: saturation with levels held
    grp_sel_i = 2'd0;
    repeat (CNT_W * 12) step();
    chk("R1 saturated U count", 32'(u_word_o[CNT_W-1:0]), 32'(CMAX));

    // main sweep: commutation with varied dwell and random strobes
    ph = 0;
    for (int k = 0; k < 120; k++) begin
      hall_lvl_i = seq[ph];
      ph = (k % 17 < 9) ? (ph + 1) % 6 : (ph + 5) % 6;
      dir_i = (k % 17 >= 9);
      dwell = $urandom_range(1, 80);
      for (int c = 0; c < dwell; c++) begin
        grp_sel_i   = 2'((c + k) % 4);
        hist_sel_i  = 2'(((c + k) / 4) % 4);
        evt_i       = NEV'($urandom) & NEV'($urandom);
        evt_rd_en_i = NEV'($urandom);
        read_cmd_i  = ($urandom % 23) == 0;
        snap_en_i   = ($urandom % 4) != 0;
        snap_i      = ($urandom % 3) == 0;
        clr_cmd_i   = ($urandom % 211) == 0;
        step();
      end
    end
    evt_i = '0; read_cmd_i = 0; snap_i = 0; clr_cmd_i = 0;

    // R4: event with enable low leaves the read set alone
    grp_sel_i = 2'd1; step();
    e_u = u_word_o;
    evt_i = 7'h7F; evt_rd_en_i = '0; step();
    evt_i = '0; step();
    chk("R4 disabled event no load", 32'(u_word_o), 32'(e_u));

    // R5: snapshot pin ignored when disabled
    grp_sel_i = 2'd2; snap_en_i = 0; step();
    e_t = tmr_o;
    snap_i = 1; step(); snap_i = 0; step(); step();
    chk("R5 disabled snapshot no load", 32'(tmr_o), 32'(e_t));

    // R8: clear wins over simultaneous loads
    read_cmd_i = 1; snap_en_i = 1; snap_i = 1; clr_cmd_i = 1; step();
    read_cmd_i = 0; snap_i = 0; clr_cmd_i = 0; grp_sel_i = 2'd1; step();
    step();
    chk("R8 read set cleared", 32'(u_word_o), 0);
    chk("R8 read timer cleared", 32'(tmr_o), 0);

    // R10: phase select 3 returns zero
    hist_sel_i = 2'd3; step(); step();
    chk("R10 hist select 3", 32'(hist_rise_o), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule